// File: doc/BRIEF.md
# Compact 8-bit Load/Add Core

This block is a small execution core with separate program and data memory ports. Each cycle in which it is ready for a new instruction, it fetches one 16-bit word from program memory and decodes it. The core implements five operations: register add, register AND, no-operation, load of an 8-bit constant, and load of a byte from data memory. It holds 32 general-purpose 8-bit registers, a zero flag and a carry flag. Two-operand operations write their result back into the first operand register.

The memory load takes two words. The first word names the destination register. The second word is the data address. The core reads the second word in the cycle after the first, presents it to the synchronous data memory with a read strobe, and writes the returned byte one cycle later. Any word outside the supported set is executed as a no-operation and raises a one-cycle illegal-opcode pulse. A combinational debug port reads any register at any time.

Top module: `byte_core`

## Requirements
- R1: While `rst_n` is low, and on release, the program address is 0. All 32 registers, both flags and `illegal_o` are 0.
- R2: A word matching `0000 11rd dddd rrrr` writes Rd + Rr into Rd. Rd = word[8:4]. Rr = {word[9], word[3:0]}.
- R3: The add sets carry to bit 8 of the 9-bit sum and sets zero when the 8-bit result is 0.
- R4: A word matching `0010 00rd dddd rrrr` (same register fields as R2) writes Rd & Rr into Rd. It sets zero when the result is 0 and leaves carry unchanged.
- R5: A word matching `1110 KKKK dddd KKKK` writes the constant {word[11:8], word[3:0]} into register 16 + word[7:4]. Flags are unchanged.
- R6: A word matching `1001 000d dddd 0000` is a memory load into Rd = word[8:4]. In the next cycle, `dmem_rd` is 1 for exactly one cycle and `dmem_addr` equals the following program word. In the cycle after that, the byte on `dmem_rdata` is written to Rd. Flags are unchanged.
- R7: `pmem_addr` rises by one after every word fetch, so a memory load advances it by two. It holds for one cycle during the load's write-back cycle.
- R8: The all-zero word changes no register and no flag, and it raises no illegal pulse.
- R9: Any other word, including a load pattern with word[3:0] nonzero, changes no register or flag. It drives `illegal_o` high in the cycle after its fetch, for one cycle per such word.
- R10: `dbg_data` shows the current content of register `dbg_sel` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr | output | 16 | Program word address |
| pmem_rdata | input | 16 | Program word at `pmem_addr` (combinational read) |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_addr | output | 16 | Data memory byte address |
| dmem_rdata | input | 8 | Data byte, valid the cycle after the strobe |
| dbg_sel | input | 5 | Register index for the debug port |
| dbg_data | output | 8 | Content of the selected register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| illegal_o | output | 1 | Illegal-opcode pulse |

## Verification
On every cycle, the assertions check how the program address moves. They check that it steps by one or holds, and that it holds in the cycle after a load's address word. They also check that the load strobe never lasts two cycles, that an illegal pulse always follows a fetch, that AND never changes carry, and that the all-zero word leaves both flags alone. The data values themselves can only be shown by the bench's scenarios. These include the split register and constant fields, carry and zero on overflow to exactly 0x100, back-to-back loads, and consecutive illegal words. The bench checks them against a reference model that reads every register through the debug port.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int NREGS   = 32;
    localparam int IDX_W   = $clog2(NREGS);

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_ADDR = 2'd1,
        PH_WB   = 2'd2
    } phase_e;

    typedef struct packed {
        logic               is_add;
        logic               is_and;
        logic               is_nop;
        logic               is_ldi;
        logic               is_lds;
        logic [IDX_W-1:0]   rd;
        logic [IDX_W-1:0]   rr;
        logic [IDX_W-1:0]   ldi_rd;
        logic [DATA_W-1:0]  imm;
    } dec_t;

endpackage

// File: rtl/core_decoder.sv
module core_decoder
    import byte_core_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output dec_t               dec_o
);
    always_comb begin
        dec_o        = '0;
        dec_o.is_add = (word_i[15:10] == 6'b000011);
        dec_o.is_and = (word_i[15:10] == 6'b001000);
        dec_o.is_nop = (word_i == '0);
        dec_o.is_ldi = (word_i[15:12] == 4'b1110);
        dec_o.is_lds = (word_i[15:9] == 7'b1001000) && (word_i[3:0] == 4'b0000);
        // destination field is contiguous, source field is split
        dec_o.rd     = word_i[8:4];
        dec_o.rr     = {word_i[9], word_i[3:0]};
        // constant load reaches only the upper half of the file
        dec_o.ldi_rd = {1'b1, word_i[7:4]};
        dec_o.imm    = {word_i[11:8], word_i[3:0]};
    end
endmodule

// File: rtl/core_alu.sv
module core_alu
    import byte_core_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sel_and_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              zero_o
);
    logic [DATA_W:0] sum;

    always_comb begin
        sum     = {1'b0, a_i} + {1'b0, b_i};
        res_o   = sel_and_i ? (a_i & b_i) : sum[DATA_W-1:0];
        carry_o = sum[DATA_W];
        zero_o  = (res_o == '0);
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import byte_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] ra_dat,
    output logic [DATA_W-1:0] rb_dat,
    output logic [DATA_W-1:0] dbg_dat,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_dat
);
    logic [DATA_W-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[w_idx] <= w_dat;
        end
    end

    assign ra_dat  = regs_q[ra_idx];
    assign rb_dat  = regs_q[rb_idx];
    assign dbg_dat = regs_q[dbg_idx];
endmodule

// File: rtl/byte_core.sv
module byte_core
    import byte_core_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [PC_W-1:0]     pmem_addr,
    input  logic [INSTR_W-1:0]  pmem_rdata,
    output logic                dmem_rd,
    output logic [INSTR_W-1:0]  dmem_addr,
    input  logic [DATA_W-1:0]   dmem_rdata,
    input  logic [IDX_W-1:0]    dbg_sel,
    output logic [DATA_W-1:0]   dbg_data,
    output logic                flag_z,
    output logic                flag_c,
    output logic                illegal_o
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        phase_e           phase;
        logic [IDX_W-1:0] ld_rd;
        logic             z;
        logic             c;
        logic             ill;
    } core_st_t;

    core_st_t          st_d, st_q;
    dec_t              dec;
    logic [DATA_W-1:0] ra_dat, rb_dat, alu_res;
    logic              alu_c, alu_z;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_widx;
    logic [DATA_W-1:0] rf_wdat;
    logic              in_run;

    core_decoder u_dec (
        .word_i (pmem_rdata),
        .dec_o  (dec)
    );

    core_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec.rd),
        .rb_idx  (dec.rr),
        .dbg_idx (dbg_sel),
        .ra_dat  (ra_dat),
        .rb_dat  (rb_dat),
        .dbg_dat (dbg_data),
        .we      (rf_we),
        .w_idx   (rf_widx),
        .w_dat   (rf_wdat)
    );

    core_alu u_alu (
        .a_i       (ra_dat),
        .b_i       (rb_dat),
        .sel_and_i (dec.is_and),
        .res_o     (alu_res),
        .carry_o   (alu_c),
        .zero_o    (alu_z)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ill = 1'b0;
        rf_we    = 1'b0;
        rf_widx  = dec.rd;
        rf_wdat  = alu_res;
        unique case (st_q.phase)
            PH_RUN: begin
                st_d.pc = st_q.pc + 1'b1;
                if (dec.is_add || dec.is_and) begin
                    rf_we  = 1'b1;
                    st_d.z = alu_z;
                    if (dec.is_add) st_d.c = alu_c;
                end else if (dec.is_ldi) begin
                    rf_we   = 1'b1;
                    rf_widx = dec.ldi_rd;
                    rf_wdat = dec.imm;
                end else if (dec.is_lds) begin
                    st_d.ld_rd = dec.rd;
                    st_d.phase = PH_ADDR;
                end else if (!dec.is_nop) begin
                    st_d.ill = 1'b1;
                end
            end
            PH_ADDR: begin
                st_d.pc    = st_q.pc + 1'b1;
                st_d.phase = PH_WB;
            end
            PH_WB: begin
                rf_we      = 1'b1;
                rf_widx    = st_q.ld_rd;
                rf_wdat    = dmem_rdata;
                st_d.phase = PH_RUN;
            end
            default: st_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_run    = (st_q.phase == PH_RUN);
    assign pmem_addr = st_q.pc;
    assign dmem_rd   = (st_q.phase == PH_ADDR);
    assign dmem_addr = pmem_rdata;
    assign flag_z    = st_q.z;
    assign flag_c    = st_q.c;
    assign illegal_o = st_q.ill;
endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pmem_addr,
    input logic [15:0]     pmem_rdata,
    input logic            dmem_rd,
    input logic            illegal_o,
    input logic            flag_z,
    input logic            flag_c,
    input logic            in_run
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pmem_addr == $past(pmem_addr) + 1'b1 || pmem_addr == $past(pmem_addr))); // R7
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> ##1 $stable(pmem_addr)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |=> !dmem_rd); // R6
    AST_ILL_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && illegal_o) |-> pmem_addr == $past(pmem_addr) + 1'b1); // R9
    AST_AND_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && pmem_rdata[15:10] == 6'b001000) |=> $stable(flag_c)); // R4
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && pmem_rdata == 16'h0000) |=> ($stable(flag_z) && $stable(flag_c) && !illegal_o)); // R8
endmodule

bind byte_core byte_core_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pmem_addr  (pmem_addr),
    .pmem_rdata (pmem_rdata),
    .dmem_rd    (dmem_rd),
    .illegal_o  (illegal_o),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .in_run     (in_run)
);

// File: tb/byte_core_tb_top.sv
`timescale 1ns/1ps
module byte_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pmem_addr;
    logic [15:0] pmem_rdata;
    logic        dmem_rd;
    logic [15:0] dmem_addr;
    logic [7:0]  dmem_rdata = 8'h00;
    logic [4:0]  dbg_sel = 5'd0;
    logic [7:0]  dbg_data;
    logic        flag_z, flag_c, illegal_o;

    logic [15:0] pmem [256];
    logic [7:0]  dmem [256];

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    assign pmem_rdata = pmem[pmem_addr[7:0]];
    always @(posedge clk) if (dmem_rd) dmem_rdata <= dmem[dmem_addr[7:0]];

    byte_core dut_i (
        .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
        .dmem_rd(dmem_rd), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .flag_z(flag_z), .flag_c(flag_c),
        .illegal_o(illegal_o)
    );

    function automatic logic [15:0] w_add(int d, int r);
        return 16'h0C00 | 16'((r >> 4) & 1) << 9 | 16'(d & 31) << 4 | 16'(r & 15);
    endfunction
    function automatic logic [15:0] w_and(int d, int r);
        return 16'h2000 | 16'((r >> 4) & 1) << 9 | 16'(d & 31) << 4 | 16'(r & 15);
    endfunction
    function automatic logic [15:0] w_ldi(int d, int k);
        return 16'hE000 | 16'((k >> 4) & 15) << 8 | 16'(d & 15) << 4 | 16'(k & 15);
    endfunction
    function automatic logic [15:0] w_lds(int d);
        return 16'h9000 | 16'(d & 31) << 4;
    endfunction

    // behavioural reference model
    int          m_pc, m_phase, m_ldrd, m_ldval;
    int          m_regs [32];
    bit          m_z, m_c, m_ill, m_fresh;
    string       m_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_phase = 0; m_z = 0; m_c = 0; m_ill = 0; m_fresh = 1;
            m_tag = "R1";
            foreach (m_regs[i]) m_regs[i] = 0;
        end else begin
            int w, d, r, s;
            m_fresh = 0;
            m_ill = 0;
            w = int'(pmem[m_pc & 255]);
            if (m_phase == 0) begin
                m_pc = (m_pc + 1) & 16'hFFFF;
                d = (w >> 4) & 31;
                r = ((w >> 5) & 16) | (w & 15);
                if ((w >> 10) == 6'b000011) begin
                    s = m_regs[d] + m_regs[r];
                    m_c = s > 255; m_regs[d] = s & 255; m_z = (m_regs[d] == 0); m_tag = "R3";
                end else if ((w >> 10) == 6'b001000) begin
                    m_regs[d] = m_regs[d] & m_regs[r]; m_z = (m_regs[d] == 0); m_tag = "R4";
                end else if ((w >> 12) == 4'hE) begin
                    m_regs[16 + ((w >> 4) & 15)] = ((w >> 4) & 240) | (w & 15); m_tag = "R5";
                end else if ((w >> 9) == 7'b1001000 && (w & 15) == 0) begin
                    m_ldrd = d; m_phase = 1; m_tag = "R6";
                end else if (w == 0) begin
                    m_tag = "R8";
                end else begin
                    m_ill = 1; m_tag = "R9";
                end
            end else if (m_phase == 1) begin
                m_ldval = int'(dmem[w & 255]);
                m_pc = (m_pc + 1) & 16'hFFFF;
                m_phase = 2;
            end else begin
                m_regs[m_ldrd] = m_ldval;
                m_phase = 0;
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            t = m_fresh ? "R1" : m_tag;
            check(m_fresh ? "R1" : "R7", "pmem_addr", int'(pmem_addr), m_pc);
            check(m_fresh ? "R1" : "R9", "illegal_o", int'(illegal_o), int'(m_ill));
            check(t, "flag_z", int'(flag_z), int'(m_z));
            check(t, "flag_c", int'(flag_c), int'(m_c));
            check("R6", "dmem_rd", int'(dmem_rd), int'(m_phase == 1));
            if (m_phase == 1)
                check("R6", "dmem_addr", int'(dmem_addr), int'(pmem[m_pc & 255]));
            check(m_fresh ? "R1" : "R10", "dbg_data", int'(dbg_data), m_regs[dbg_sel]);
        end
    end

    initial forever @(posedge clk) dbg_sel <= dbg_sel + 5'd1;

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        foreach (pmem[i]) pmem[i] = 16'h0000;
        foreach (dmem[i]) dmem[i] = 8'(i * 7 + 1);
        dmem[8'h33] = 8'hA5; dmem[8'h44] = 8'h5A; dmem[8'h12] = 8'h80;
        pmem[0]  = w_ldi(0, 8'hF0);   // R5 -> r16
        pmem[1]  = w_ldi(15, 8'h20);  // R5 -> r31
        pmem[2]  = w_ldi(1, 8'h10);   // r17
        pmem[3]  = w_ldi(2, 8'hF0);   // r18
        pmem[4]  = w_add(16, 31);     // R2 split field, R3 carry
        pmem[5]  = w_add(18, 17);     // R3 sum 0x100: zero and carry
        pmem[6]  = w_and(17, 31);     // R4 zero, carry kept
        pmem[7]  = w_lds(3);          // R6
        pmem[8]  = 16'h0033;
        pmem[9]  = w_lds(30);         // R6 back to back, high Rd bit
        pmem[10] = 16'h0044;
        pmem[11] = w_add(3, 30);      // 0xFF, no carry
        pmem[12] = w_and(3, 31);
        pmem[13] = 16'hFFFF;          // R9
        pmem[14] = 16'h0400;          // R9 consecutive
        pmem[15] = 16'h0000;          // R8
        pmem[16] = w_add(0, 3);
        pmem[17] = w_add(3, 3);
        pmem[18] = w_and(0, 0);
        pmem[19] = w_lds(8);
        pmem[20] = 16'h0012;
        pmem[21] = w_add(8, 8);       // 0x80+0x80
        pmem[22] = 16'h9031;          // R9 load pattern with nonzero low nibble
        pmem[23] = w_ldi(15, 8'h00);  // R5 zero constant, flags unchanged
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (60) @(posedge clk);
        #1 rst_n = 1'b0;              // R1 reset during operation
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (45) @(posedge clk);
        @(negedge clk);
        #1 done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule